// File: doc/BRIEF.md
# Counted Pulse and Clock Burst Generator

This block drives a single output with a programmed number of base periods, then raises a completion flag. One configuration word picks the length of a base period in system clocks (low half) and a compare threshold (high half). A down-counter runs from the period length to 1 in every base period, and the output is high while the counter is above the threshold. That gives a burst of square waves, pulses or one long high level. A separate count word gives the number of base periods to produce. A non-zero write to it starts the burst.

The usual job is to make a bus clock of known length. A data streamer elsewhere on the chip can then be phase-aligned to it. An enable input works as a soft reset: while it is low the block is idle and its count is cleared. The block also has a synchronous active-high reset.

Top module: `pulse_cycle_gen`

## Requirements
- R1: While `dir_en` is 0, `pin_out` and `done_out` are 0 and the remaining count is forced to zero. After `dir_en` returns to 1, no output is produced until a new non-zero count is written.
- R2: The base period P is `x_data[15:0]`, with written values 0 and 1 taken as 2. Every base period lasts exactly P clocks.
- R3: In every base period the counter takes the values P, P-1, ... 1, and `pin_out` is 1 while the counter is greater than T = `x_data[31:16]`. So each period begins with max(0, P-T) high clocks and ends low. When T >= P the output stays low.
- R4: With T = 0 the output is high on every clock of the burst.
- R5: A non-zero write to the count starts a base period in the very next clock. The burst then lasts exactly count × P clocks.
- R6: At the end of the burst, `pin_out` goes low and `done_out` goes high in the clock that follows the last period. `done_out` stays high until the count is written again or `dir_en` goes low.
- R7: Writing a count of zero during a burst stops it in the next clock, with `pin_out` low and `done_out` high.
- R8: A configuration write during a burst does not change the current base period. It applies from the next period reload. A configuration write in the same clock as a count write applies to the first period.
- R9: A non-zero count write during a burst restarts it with the new count from the next clock, and clears `done_out`.
- R10: Dropping `dir_en` during a burst stops the output in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_en | input | 1 | Enable; 0 holds the block idle and clears its count |
| x_wr | input | 1 | Strobe for the configuration word |
| x_data | input | 32 | [15:0] base period, [31:16] compare threshold |
| y_wr | input | 1 | Strobe for the count word |
| y_data | input | Y_W | Number of base periods; zero stops a burst |
| pin_out | output | 1 | Generated output level |
| done_out | output | 1 | Completion flag |

## Verification
The bench tries several period and threshold pairs: a 1-0-0 pulse, a balanced square wave, T = 0, T above P, and the period values 0 and 1 that are folded to 2. Comparing the total burst length with the high-clock count separates a wrong period length from a wrong compare. A sampled first period separates a high-first waveform from a shifted one. Writes that arrive mid-burst (a new count, zero, new configuration, enable dropped) check that each one acts at its own boundary: the next clock for a count write or an enable drop, and the next reload for a configuration write.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

    localparam int PER_W = 16;
    localparam int X_W   = 2 * PER_W;

    typedef struct packed {
        logic [PER_W-1:0] thresh;
        logic [PER_W-1:0] period;
    } pgen_cfg_t;

    function automatic logic [PER_W-1:0] fold_period(input logic [PER_W-1:0] p);
        return (p < PER_W'(2)) ? PER_W'(2) : p;
    endfunction

    function automatic pgen_cfg_t make_cfg(input logic [X_W-1:0] word);
        pgen_cfg_t c;
        c = pgen_cfg_t'(word);
        c.period = fold_period(c.period);
        return c;
    endfunction

endpackage

// File: rtl/pgen_cfg.sv
module pgen_cfg
    import pgen_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           x_wr,
    input  logic [X_W-1:0] x_data,
    input  logic           load,
    output pgen_cfg_t      cfg_next,
    output pgen_cfg_t      cfg_act
);
    pgen_cfg_t pend_q;

    always_comb begin
        cfg_next = x_wr ? make_cfg(x_data) : pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '{thresh: '0, period: PER_W'(2)};
            cfg_act <= '{thresh: '0, period: PER_W'(2)};
        end else begin
            if (x_wr) pend_q <= make_cfg(x_data);
            if (load) cfg_act <= cfg_next;
        end
    end

    assert_period_folded_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_act.period >= PER_W'(2));

    assert_hold_until_reload_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_act));
endmodule

// File: rtl/pgen_timer.sv
module pgen_timer
    import pgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      run,
    input  pgen_cfg_t cfg_next,
    input  pgen_cfg_t cfg_act,
    output logic      period_end,
    output logic      pin
);
    logic [PER_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= cfg_next.period;
        end else if (run && cnt_q > PER_W'(1)) begin
            cnt_q <= cnt_q - PER_W'(1);
        end
    end

    always_comb begin
        period_end = run && (cnt_q == PER_W'(1));
        pin        = run && (cnt_q > cfg_act.thresh);
    end

    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q >= PER_W'(1) && cnt_q <= cfg_act.period));

    assert_cnt_steps_down_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !load && cnt_q > PER_W'(1)) |=> (cnt_q == $past(cnt_q) - PER_W'(1)));
endmodule

// File: rtl/pgen_seq.sv
module pgen_seq #(
    parameter int Y_W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           dir_en,
    input  logic           y_wr,
    input  logic [Y_W-1:0] y_data,
    input  logic           period_end,
    output logic           run,
    output logic           done,
    output logic           load
);
    logic [Y_W-1:0] left_q;
    logic           start;
    logic           last;

    always_comb begin
        start = y_wr && (y_data != '0);
        last  = (left_q == Y_W'(1));
        load  = dir_en && (start || (!y_wr && period_end && !last));
    end

    always_ff @(posedge clk) begin
        if (rst || !dir_en) begin
            run    <= 1'b0;
            done   <= 1'b0;
            left_q <= '0;
        end else if (y_wr) begin
            if (start) begin
                run    <= 1'b1;
                done   <= 1'b0;
                left_q <= y_data;
            end else begin
                run    <= 1'b0;
                done   <= run;
                left_q <= '0;
            end
        end else if (period_end) begin
            if (last) begin
                run    <= 1'b0;
                done   <= 1'b1;
                left_q <= '0;
            end else begin
                left_q <= left_q - Y_W'(1);
            end
        end
    end

    assert_start_next_R5: assert property (@(posedge clk) disable iff (rst)
        (dir_en && start) |=> (run && !done));

    assert_zero_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (dir_en && y_wr && !start && run) |=> (!run && done));

    assert_finish_R6: assert property (@(posedge clk) disable iff (rst)
        (dir_en && !y_wr && period_end && last) |=> (!run && done));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (dir_en && done && !y_wr) |=> done);

    assert_never_both_R6: assert property (@(posedge clk) disable iff (rst)
        !(run && done));
endmodule

// File: rtl/pulse_cycle_gen.sv
module pulse_cycle_gen
    import pgen_pkg::*;
#(
    parameter int Y_W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           dir_en,
    input  logic           x_wr,
    input  logic [X_W-1:0] x_data,
    input  logic           y_wr,
    input  logic [Y_W-1:0] y_data,
    output logic           pin_out,
    output logic           done_out
);
    pgen_cfg_t cfg_next;
    pgen_cfg_t cfg_act;
    logic      load;
    logic      run;
    logic      period_end;
    logic      pin;
    logic      done;

    pgen_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .x_wr     (x_wr),
        .x_data   (x_data),
        .load     (load),
        .cfg_next (cfg_next),
        .cfg_act  (cfg_act)
    );

    pgen_seq #(.Y_W(Y_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .dir_en     (dir_en),
        .y_wr       (y_wr),
        .y_data     (y_data),
        .period_end (period_end),
        .run        (run),
        .done       (done),
        .load       (load)
    );

    pgen_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .run        (run),
        .cfg_next   (cfg_next),
        .cfg_act    (cfg_act),
        .period_end (period_end),
        .pin        (pin)
    );

    assign pin_out  = pin;
    assign done_out = done;

    assert_idle_when_disabled_R1: assert property (@(posedge clk) disable iff (rst)
        !dir_en |=> (!pin_out && !done_out));

    assert_drop_stops_R10: assert property (@(posedge clk) disable iff (rst)
        (!dir_en && !$past(dir_en)) |-> !pin_out);
endmodule

// File: tb/pulse_cycle_gen_test.sv
module pulse_cycle_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dir_en = 1'b0;
    logic        x_wr = 1'b0;
    logic [31:0] x_data = '0;
    logic        y_wr = 1'b0;
    logic [31:0] y_data = '0;
    logic        pin_out;
    logic        done_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pulse_cycle_gen #(.Y_W(32)) uut (
        .clk(clk), .rst(rst), .dir_en(dir_en),
        .x_wr(x_wr), .x_data(x_data),
        .y_wr(y_wr), .y_data(y_data),
        .pin_out(pin_out), .done_out(done_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_x(input int per, input int thr);
        x_wr = 1'b1; x_data = {thr[15:0], per[15:0]};
        @(negedge clk);
        x_wr = 1'b0;
    endtask

    task automatic write_y(input int cnt);
        y_wr = 1'b1; y_data = cnt;
        @(negedge clk);
        y_wr = 1'b0;
    endtask

    // Counts clocks of burst and high clocks from the current negedge to done.
    task automatic measure(output int cyc, output int hi);
        cyc = 0; hi = 0;
        while (!done_out && cyc < 5000) begin
            if (pin_out) hi++;
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic burst(input string req, input int per, input int thr,
                         input int cnt, input int exp_p);
        int cyc, hi, exp_hi;
        write_x(per, thr);
        write_y(cnt);
        measure(cyc, hi);
        exp_hi = (exp_p > thr) ? exp_p - thr : 0;
        check({req, " length"}, cyc, cnt * exp_p);
        check({req, " high clocks"}, hi, cnt * exp_hi);
        check({req, " pin low at end"}, int'(pin_out), 0);
    endtask

    task automatic t_reset();
        check("R1 reset pin", int'(pin_out), 0);
        check("R1 reset done", int'(done_out), 0);
    endtask

    task automatic t_shape();
        int seen[3];
        write_x(3, 2);
        write_y(2);
        for (int i = 0; i < 3; i++) begin
            seen[i] = int'(pin_out);
            @(negedge clk);
        end
        check("R3 first clock high", seen[0], 1);
        check("R3 second clock low", seen[1], 0);
        check("R3 third clock low", seen[2], 0);
        repeat (3) @(negedge clk);
        check("R6 done after last period", int'(done_out), 1);
    endtask

    task automatic t_done_hold();
        write_x(4, 2);
        write_y(1);
        repeat (4) @(negedge clk);
        repeat (6) @(negedge clk);
        check("R6 done held", int'(done_out), 1);
        check("R6 pin low while done", int'(pin_out), 0);
    endtask

    task automatic t_zero_stop();
        write_x(10, 0);
        write_y(100);
        repeat (7) @(negedge clk);
        check("R7 running before stop", int'(pin_out), 1);
        write_y(0);
        check("R7 pin low after zero", int'(pin_out), 0);
        check("R7 done after zero", int'(done_out), 1);
    endtask

    task automatic t_x_live();
        int cyc, hi;
        write_x(4, 0);
        write_y(3);
        write_x(2, 0);           // applies from second period
        measure(cyc, hi);
        check("R8 remaining length", cyc, 7);
        check("R8 remaining high", hi, 7);
    endtask

    task automatic t_restart();
        int cyc, hi;
        write_x(3, 1);
        write_y(10);
        repeat (4) @(negedge clk);
        write_y(2);
        check("R9 done cleared on rewrite", int'(done_out), 0);
        measure(cyc, hi);
        check("R9 restarted length", cyc, 6);
        check("R9 restarted high", hi, 4);
    endtask

    task automatic t_dir();
        int hi;
        write_x(5, 0);
        write_y(50);
        repeat (3) @(negedge clk);
        dir_en = 1'b0;
        @(negedge clk);
        check("R10 pin low after drop", int'(pin_out), 0);
        check("R1 done low while disabled", int'(done_out), 0);
        dir_en = 1'b1;
        hi = 0;
        for (int i = 0; i < 12; i++) begin
            if (pin_out || done_out) hi++;
            @(negedge clk);
        end
        check("R1 count cleared by disable", hi, 0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        dir_en = 1'b1;
        @(negedge clk);
        t_reset();
        t_shape();
        burst("R2 R3 square", 4, 2, 3, 4);
        burst("R4 all high", 5, 0, 2, 5);
        burst("R2 period zero", 0, 1, 3, 2);
        burst("R2 period one", 1, 1, 3, 2);
        burst("R3 threshold above period", 3, 5, 2, 3);
        burst("R5 long count", 7, 3, 9, 7);
        t_done_hold();
        t_zero_stop();
        t_x_live();
        t_restart();
        t_dir();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule